// File: doc/BRIEF.md
# Cascaded second-level interrupt aggregator

This block gathers up to 32 level-sensitive interrupt sources and presents them to a parent interrupt controller on a small number of lines. Each group output is built from the sources named in that output's map mask, fixed at elaboration. Only sources that software has unmasked count, and the outputs of the groups are ORed together per line. A forward mask, also fixed at elaboration, names sources that take a bypass path instead. Each forwarded source drives its own dedicated parent line, and the enable register has no effect on it. If a forwarded source also appears in a map mask, it is removed from that group.

Software sees two 32-bit words. The enable word sits at byte offset 0x0, where 1 unmasks a source and 0 masks it. The status word sits at byte offset 0x4 and is read-only. It returns the synchronized source levels, ANDed with the enable word and with the union of the group map masks. A zero status word therefore means that no enabled group source is pending. Bit positions covered by no mask have no source behind them. Sources are levels, so there is nothing to acknowledge: a line stays high until its source drops or is masked.

Top module: `irq_cascade_agg`

## Requirements
- R1: While reset is held and on the first cycle after it, every group and forward output is 0 and the enable and status words read as 0.
- R2: A write to offset 0x0 stores the write data ANDed with the connected mask. The connected mask is the union of all map masks and the forward mask (0xFFF by default). A read of offset 0x0 returns the stored value.
- R3: A read of offset 0x4 returns src & enable & G. G is the union of the map masks with the forwarded bits cleared (0xFF8 by default). The value is taken after a two-flop synchronizer, so a source change appears there two clock edges later.
- R4: Group output k equals the registered OR of src & enable & map[k] with the forwarded bits cleared. By default map[0] is 0xEB8 and map[1] is 0x140. The output changes on the third edge after a source change and on the second edge after the enable write edge.
- R5: Forward output i follows the i-th set bit of the forward mask, counted upward from bit 0 (by default sources 0, 1 and 2). It does so with a latency of three edges and whatever the enable word holds.
- R6: Unconnected source bits (12 to 31 by default) never assert any output, and they read as 0 in both the status word and the enable word.
- R7: Writes to any offset other than 0x0 leave the enable word unchanged. Reads of offsets other than 0x0 and 0x4 return 0.
- R8: A group output stays high as long as an enabled source in its group stays high. It falls three edges after that source drops, or one edge after the write that masks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | SRC_W | Level-sensitive source inputs, asynchronous |
| bus_addr_i | input | ADDR_W | Byte offset for register access |
| bus_wen_i | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata_i | input | SRC_W | Write data |
| bus_rdata_o | output | SRC_W | Combinational read data for bus_addr_i |
| grp_irq_o | output | NUM_OUT | Group lines toward the parent controller |
| fwd_irq_o | output | NUM_FWD | Dedicated bypass lines toward the parent controller |

## Verification
On every cycle, the assertions check four things:
- a group line is only raised after an enable bit in its group was set;
- writes to any offset but the enable word leave that word untouched;
- a status read never shows bits outside the group sources;
- each forward line repeats its source exactly three edges later.

Other behaviour can only be shown by the bench's scenarios. This covers the exact OR result per group against random source and enable patterns, and the masking of unconnected bits in the enable word. It also covers the edge counts at which a line rises, falls after its source drops, or falls after a masking write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int MAX_W  = 64;
    localparam int OFS_EN = 0;
    localparam int OFS_ST = 4;

    function automatic int popcount(logic [MAX_W-1:0] m);
        int n;
        n = 0;
        for (int b = 0; b < MAX_W; b++) begin
            if (m[b]) n++;
        end
        return n;
    endfunction

    // Position of the idx-th set bit, counting upward from bit 0.
    function automatic int nth_set(logic [MAX_W-1:0] m, int idx);
        int seen;
        int pos;
        seen = 0;
        pos  = 0;
        for (int b = 0; b < MAX_W; b++) begin
            if (m[b]) begin
                if (seen == idx) pos = b;
                seen++;
            end
        end
        return pos;
    endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] async_i,
    output logic [SRC_W-1:0] sync_o
);

    typedef struct packed {
        logic [SRC_W-1:0] s1;
        logic [SRC_W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int               SRC_W     = 32,
    parameter int               ADDR_W    = 4,
    parameter logic [SRC_W-1:0] CONN_MASK = '1,
    parameter logic [SRC_W-1:0] GRP_MASK  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wen_i,
    input  logic [SRC_W-1:0]  wdata_i,
    input  logic [SRC_W-1:0]  sync_i,
    output logic [SRC_W-1:0]  en_o,
    output logic [SRC_W-1:0]  rdata_o
);

    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(OFS_ST);

    typedef struct packed {
        logic [SRC_W-1:0] en;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [SRC_W-1:0] status;

    always_comb begin
        rg_d = rg_q;
        if (wen_i && (addr_i == A_EN)) begin
            rg_d.en = wdata_i & CONN_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        status = sync_i & rg_q.en & GRP_MASK;
        if (addr_i == A_EN)      rdata_o = rg_q.en;
        else if (addr_i == A_ST) rdata_o = status;
        else                     rdata_o = '0;
    end

    assign en_o = rg_q.en;

    AST_OTHER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_i && (addr_i != A_EN)) |=> $stable(en_o)); // R7

endmodule

// File: rtl/irq_agg_route.sv
module irq_agg_route
    import irq_agg_pkg::*;
#(
    parameter int                              SRC_W    = 32,
    parameter int                              NUM_OUT  = 2,
    parameter logic [NUM_OUT-1:0][SRC_W-1:0]   OUT_MAP  = '0,
    parameter logic [SRC_W-1:0]                FWD_MASK = '0,
    parameter int                              NUM_FWD  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   sync_i,
    input  logic [SRC_W-1:0]   en_i,
    output logic [NUM_OUT-1:0] grp_o,
    output logic [NUM_FWD-1:0] fwd_o
);

    typedef struct packed {
        logic [NUM_OUT-1:0] grp;
        logic [NUM_FWD-1:0] fwd;
    } route_t;

    route_t rt_d, rt_q;
    logic [SRC_W-1:0] gated;

    always_comb begin
        gated = sync_i & en_i & ~FWD_MASK;
        for (int k = 0; k < NUM_OUT; k++) begin
            rt_d.grp[k] = |(gated & OUT_MAP[k]);
        end
        for (int i = 0; i < NUM_FWD; i++) begin
            rt_d.fwd[i] = sync_i[nth_set(MAX_W'(FWD_MASK), i)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign grp_o = rt_q.grp;
    assign fwd_o = rt_q.fwd;

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
        AST_GRP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            grp_o[k] |-> ($past(en_i & OUT_MAP[k]) != '0)); // R4
    end

endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
    import irq_agg_pkg::*;
#(
    parameter int                            SRC_W    = 32,
    parameter int                            NUM_OUT  = 2,
    parameter logic [NUM_OUT-1:0][SRC_W-1:0] OUT_MAP  = {32'h0000_0140, 32'h0000_0EB8},
    parameter logic [SRC_W-1:0]              FWD_MASK = 32'h0000_0007,
    parameter int                            ADDR_W   = 4,
    localparam int                           NUM_FWD  = popcount(MAX_W'(FWD_MASK))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   src_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_wen_i,
    input  logic [SRC_W-1:0]   bus_wdata_i,
    output logic [SRC_W-1:0]   bus_rdata_o,
    output logic [NUM_OUT-1:0] grp_irq_o,
    output logic [NUM_FWD-1:0] fwd_irq_o
);

    function automatic logic [SRC_W-1:0] map_union();
        logic [SRC_W-1:0] u;
        u = '0;
        for (int k = 0; k < NUM_OUT; k++) u |= OUT_MAP[k];
        return u;
    endfunction

    localparam logic [SRC_W-1:0] MAP_ALL   = map_union();
    localparam logic [SRC_W-1:0] CONN_MASK = MAP_ALL | FWD_MASK;
    localparam logic [SRC_W-1:0] GRP_MASK  = MAP_ALL & ~FWD_MASK;
    localparam logic [ADDR_W-1:0] A_ST     = ADDR_W'(OFS_ST);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_ovl_i
        for (genvar j = i + 1; j < NUM_OUT; j++) begin : g_ovl_j
            if ((OUT_MAP[i] & OUT_MAP[j]) != '0) begin : g_bad
                $error("map masks %0d and %0d share source bits", i, j);
            end
        end
    end

    logic [SRC_W-1:0] sync_src;
    logic [SRC_W-1:0] en;

    irq_agg_sync #(.SRC_W(SRC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (sync_src)
    );

    irq_agg_regs #(
        .SRC_W     (SRC_W),
        .ADDR_W    (ADDR_W),
        .CONN_MASK (CONN_MASK),
        .GRP_MASK  (GRP_MASK)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr_i),
        .wen_i   (bus_wen_i),
        .wdata_i (bus_wdata_i),
        .sync_i  (sync_src),
        .en_o    (en),
        .rdata_o (bus_rdata_o)
    );

    irq_agg_route #(
        .SRC_W    (SRC_W),
        .NUM_OUT  (NUM_OUT),
        .OUT_MAP  (OUT_MAP),
        .FWD_MASK (FWD_MASK),
        .NUM_FWD  (NUM_FWD)
    ) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_src),
        .en_i   (en),
        .grp_o  (grp_irq_o),
        .fwd_o  (fwd_irq_o)
    );

    // Cycles since reset, saturating, for the latency check below.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    AST_STATUS_ONLY_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == A_ST) |-> ((bus_rdata_o & ~GRP_MASK) == '0)); // R6

    for (genvar i = 0; i < NUM_FWD; i++) begin : g_fwd_chk
        localparam int POS = nth_set(MAX_W'(FWD_MASK), i);
        AST_FWD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd3) |-> (fwd_irq_o[i] == $past(src_i[POS], 3))); // R5
    end

endmodule

// File: tb/irq_cascade_agg_tb.sv
module irq_cascade_agg_tb;

    localparam logic [31:0] MAP0 = 32'h0000_0EB8;
    localparam logic [31:0] MAP1 = 32'h0000_0140;
    localparam logic [31:0] FWD  = 32'h0000_0007;
    localparam logic [31:0] CONN = 32'h0000_0FFF;
    localparam logic [31:0] GRPM = 32'h0000_0FF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [3:0]  addr = '0;
    logic        wen = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  grp;
    logic [2:0]  fwd;

    logic [31:0] en_m = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_cascade_agg u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_wen_i   (wen),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .grp_irq_o   (grp),
        .fwd_irq_o   (fwd)
    );

    function automatic logic [1:0] exp_grp(logic [31:0] s, logic [31:0] e);
        return {|(s & e & MAP1 & ~FWD), |(s & e & MAP0 & ~FWD)};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        addr = a; wdata = d; wen = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wen = 1'b0;
        if (a == 4'h0) en_m = d & CONN;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(string req);
        logic [31:0] v;
        rd(4'h0, v);  check(req, "enable", v, en_m);
        rd(4'h4, v);  check(req, "status", v, src & en_m & GRPM);
        check(req, "grp", 32'(grp), 32'(exp_grp(src, en_m)));
        check(req, "fwd", 32'(fwd), src & FWD);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h1234_5EED));
        src = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1", "grp in reset", 32'(grp), 0);
        check("R1", "fwd in reset", 32'(fwd), 0);
        rd(4'h0, v); check("R1", "enable in reset", v, 0);
        src = '0;
        @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R1", "grp after reset", 32'(grp), 0);
        rd(4'h4, v); check("R1", "status after reset", v, 0);

        // R2: enable write masked to connected bits
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R2", "enable all ones", v, 32'h0000_0FFF);
        wr(4'h0, 32'h1234_5678);
        rd(4'h0, v); check("R2", "enable pattern", v, 32'h0000_0678);

        // R7: other offsets ignored on write, zero on read
        src = 32'hFFFF_FFFF;
        wr(4'h4, 32'h0);
        rd(4'h0, v); check("R7", "enable after status write", v, 32'h0000_0678);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R7", "enable after 0x8 write", v, 32'h0000_0678);
        settle();
        rd(4'h8, v); check("R7", "read 0x8", v, 0);
        rd(4'hC, v); check("R7", "read 0xC", v, 0);

        // R6: unconnected sources only
        wr(4'h0, 32'hFFFF_FFFF);
        src = 32'hFFFF_F000;
        settle();
        check("R6", "grp unconnected", 32'(grp), 0);
        check("R6", "fwd unconnected", 32'(fwd), 0);
        rd(4'h4, v); check("R6", "status unconnected", v, 0);

        // R5: forwarding ignores the enable word
        wr(4'h0, 32'h0);
        src = 32'h0000_0007;
        settle();
        check("R5", "fwd with enable clear", 32'(fwd), 32'h7);
        check("R5", "grp with enable clear", 32'(grp), 0);
        src = 32'h0000_0005;
        settle();
        check("R5", "fwd pattern 5", 32'(fwd), 32'h5);

        // R4/R8 latency: rising source, three edges
        wr(4'h0, 32'hFFF);
        src = 32'h0000_0008;
        step(); check("R4", "grp0 edge1", 32'(grp[0]), 0);
        step(); check("R4", "grp0 edge2", 32'(grp[0]), 0);
        step(); check("R4", "grp0 edge3", 32'(grp[0]), 1);
        step(); check("R8", "grp0 held", 32'(grp[0]), 1);
        src = 32'h0;
        step(); check("R8", "grp0 fall edge1", 32'(grp[0]), 1);
        step(); check("R8", "grp0 fall edge2", 32'(grp[0]), 1);
        step(); check("R8", "grp0 fall edge3", 32'(grp[0]), 0);

        // R8: masking drops the line one edge after the write edge
        src = 32'h0000_0040;
        settle();
        check("R8", "grp1 set", 32'(grp[1]), 1);
        wr(4'h0, 32'h0);
        check("R8", "grp1 at write edge", 32'(grp[1]), 1);
        step(); check("R8", "grp1 masked", 32'(grp[1]), 0);

        // R4: enable write raises the line on the second edge
        addr = 4'h0; wdata = 32'h40; wen = 1'b1;
        @(posedge clk); @(negedge clk); wen = 1'b0; en_m = 32'h40;
        check("R4", "grp1 after enable edge", 32'(grp[1]), 0);
        step(); check("R4", "grp1 next edge", 32'(grp[1]), 1);

        // R3/R4/R5: random patterns
        for (int n = 0; n < 60; n++) begin
            wr(4'h0, $urandom);
            src = $urandom;
            settle();
            check_all("R3");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule